// File: doc/BRIEF.md
# Exception Entry Register Unit

This unit commits all of a processor's control-register side effects for taking an exception, in one clock edge. A single-cycle request carries a class code, an event code, the faulting virtual address, the way index of the translation entry that matched, the current PC, the current status word and an 8-bit trap immediate. The unit loads the registers each class touches and leaves the others alone. It then raises a redirect strobe, with the handler address, in the cycle after the request.

Three classes exist: a translation protection fault, an address error and an unconditional trap. The two faults save the PC of the faulting instruction. The trap is a completion-type event, so it saves the PC of the next 16-bit instruction. Each class also forces the block, privileged-mode and bank bits of the status register to 1. The handler entry is always the vector base plus 0x100.

A small software port reads and writes the nine registers by index. It is a combinational read with a clocked write.

Top module: `exc_entry_unit`

## Requirements
- R1: A request of class 0 (protection fault) or class 1 (address error) loads the full 32-bit reqAddr into the fault-address register (index 0).
- R2: A class 0 request writes reqAddr[31:10] into bits 31:10 of the page-high register (index 1) and keeps its bits 9:0. It writes reqWay into bits 7:6 of the MMU control register (index 2) and keeps that register's other bits. A class 1 request changes neither register.
- R3: A class 0 or class 1 request loads reqPc into saved-PC (index 3), reqSr into saved-SR (index 4) and reqEvtCode, zero-extended, into the event register (index 5). It leaves the trap register (index 6) unchanged.
- R4: A class 2 (trap) request loads reqPc+2 into saved-PC and reqSr into saved-SR. It sets the event register to 0x160 and the trap register to reqImm*4 in bits 9:0 with all upper bits zero. Indexes 0, 1 and 2 are unchanged.
- R5: Any accepted request loads the status register (index 7) with reqSr, with bits 28, 29 and 30 forced to 1.
- R6: redirectValid is 1 exactly in the cycle after an accepted request. In that cycle redirectPc equals the vector base register (index 8), as it was before the request, plus 0x100. At all other times redirectPc is 0.
- R7: A request of class 3 is ignored: no register changes and no redirect.
- R8: With swWrEn set, swWrData is written to the register at swAddr on the clock edge. swRdData always shows the register at swAddr. Indexes 9 to 15 read 0, and writes to them have no effect.
- R9: A software write is dropped when it falls in a cycle where redirectValid is 1, or in the same cycle as an accepted request.
- R10: After reset every register reads 0 and redirectValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Exception request, one cycle |
| reqClass | input | 2 | 0 protection fault, 1 address error, 2 trap, 3 none |
| reqEvtCode | input | 12 | Event code for fault classes |
| reqAddr | input | 32 | Faulting virtual address |
| reqWay | input | 2 | Way index of the faulting entry |
| reqPc | input | 32 | PC of the excepting instruction |
| reqSr | input | 32 | Status word at the time of the exception |
| reqImm | input | 8 | Trap immediate |
| swWrEn | input | 1 | Software write enable |
| swAddr | input | 4 | Software register index |
| swWrData | input | 32 | Software write data |
| swRdData | output | 32 | Software read data |
| redirectValid | output | 1 | Handler redirect strobe |
| redirectPc | output | 32 | Handler address |

## Verification
A wrong decode of the class shows up on the first readback after the request. It appears as a changed register that should have held, or as a held register that should have changed. A wrong PC offset, event code or trap shift shows in saved-PC, the event register or the trap register in the cycle right after the edge. Errors in the redirect timing or in the write-blocking show the same cycle at redirectValid and redirectPc, or one cycle later at the register that the dropped write targeted. The reference model therefore sweeps every register index and both redirect outputs in every cycle.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/100ps
package exc_entry_pkg;

  typedef enum logic [1:0] {
    EXC_PROT = 2'd0,
    EXC_ADDR = 2'd1,
    EXC_TRAP = 2'd2,
    EXC_NONE = 2'd3
  } exc_class_e;

  localparam int REG_FAULT = 0;
  localparam int REG_PAGE  = 1;
  localparam int REG_MMUC  = 2;
  localparam int REG_SPC   = 3;
  localparam int REG_SSR   = 4;
  localparam int REG_EVT   = 5;
  localparam int REG_TRAP  = 6;
  localparam int REG_SR    = 7;
  localparam int REG_VEC   = 8;
  localparam int NUM_REGS  = 9;

  localparam int TRAP_EVT   = 'h160;
  localparam int VEC_OFFSET = 'h100;
  localparam int INSN_BYTES = 2;

  typedef struct packed {
    logic take;
    logic isProt;
    logic isFault;
    logic isTrap;
    logic swWe;
  } ctrl_t;

endpackage

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/100ps
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqClass,
  input  logic             swWrEn,
  input  logic [SEL_W-1:0] swAddr,
  output ctrl_t            ctrl,
  output logic             redirectValid
);

  exc_class_e cls;
  logic       selInRange;

  always_comb begin
    cls        = exc_class_e'(reqClass);
    selInRange = (int'(swAddr) < NUM_REGS);
    ctrl.take    = reqValid && (cls != EXC_NONE);
    ctrl.isProt  = reqValid && (cls == EXC_PROT);
    ctrl.isFault = reqValid && ((cls == EXC_PROT) || (cls == EXC_ADDR));
    ctrl.isTrap  = reqValid && (cls == EXC_TRAP);
    ctrl.swWe    = swWrEn && selInRange && !ctrl.take && !redirectValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) redirectValid <= 1'b0;
    else       redirectValid <= ctrl.take;
  end

endmodule

// File: rtl/exc_entry_dp.sv
`timescale 1ns/100ps
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int EVT_W   = 12,
  parameter int IMM_W   = 8,
  parameter int WAY_W   = 2,
  parameter int WAY_LSB = 6,
  parameter int VPN_LSB = 10,
  parameter int SR_BL   = 28,
  parameter int SR_RB   = 29,
  parameter int SR_MD   = 30,
  parameter int SEL_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic [EVT_W-1:0] reqEvtCode,
  input  logic [XLEN-1:0]  reqAddr,
  input  logic [WAY_W-1:0] reqWay,
  input  logic [XLEN-1:0]  reqPc,
  input  logic [XLEN-1:0]  reqSr,
  input  logic [IMM_W-1:0] reqImm,
  input  logic [SEL_W-1:0] swAddr,
  input  logic [XLEN-1:0]  swWrData,
  output logic [XLEN-1:0]  swRdData,
  output logic [XLEN-1:0]  redirectPc,
  output logic [XLEN-1:0]  srQ,
  output logic [XLEN-1:0]  vecBaseQ
);

  localparam logic [XLEN-1:0] SR_FORCE =
    (XLEN'(1) << SR_BL) | (XLEN'(1) << SR_RB) | (XLEN'(1) << SR_MD);
  localparam logic [XLEN-1:0] TRAP_CODE = XLEN'(TRAP_EVT);
  localparam logic [XLEN-1:0] VEC_OFS   = XLEN'(VEC_OFFSET);
  localparam logic [XLEN-1:0] PC_STEP   = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] regQ [NUM_REGS];
  logic [XLEN-1:0] regD [NUM_REGS];
  logic            regEn[NUM_REGS];

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      regD[i]  = regQ[i];
      regEn[i] = 1'b0;
      if (ctrl.swWe && (swAddr == SEL_W'(i))) begin
        regD[i]  = swWrData;
        regEn[i] = 1'b1;
      end
    end

    if (ctrl.take) begin
      regD[REG_SSR]  = reqSr;
      regEn[REG_SSR] = 1'b1;
      regD[REG_SR]   = reqSr | SR_FORCE;
      regEn[REG_SR]  = 1'b1;
    end

    if (ctrl.isFault) begin
      regD[REG_FAULT]  = reqAddr;
      regEn[REG_FAULT] = 1'b1;
      regD[REG_SPC]    = reqPc;
      regEn[REG_SPC]   = 1'b1;
      regD[REG_EVT]    = XLEN'(reqEvtCode);
      regEn[REG_EVT]   = 1'b1;
    end

    if (ctrl.isProt) begin
      regD[REG_PAGE]  = {reqAddr[XLEN-1:VPN_LSB], regQ[REG_PAGE][VPN_LSB-1:0]};
      regEn[REG_PAGE] = 1'b1;
      regD[REG_MMUC][WAY_LSB +: WAY_W] = reqWay;
      regEn[REG_MMUC] = 1'b1;
    end

    if (ctrl.isTrap) begin
      regD[REG_SPC]   = reqPc + PC_STEP;
      regEn[REG_SPC]  = 1'b1;
      regD[REG_EVT]   = TRAP_CODE;
      regEn[REG_EVT]  = 1'b1;
      regD[REG_TRAP]  = XLEN'({reqImm, 2'b00});
      regEn[REG_TRAP] = 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN)         regQ[g] <= '0;
      else if (regEn[g]) regQ[g] <= regD[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          redirectPc <= '0;
    else if (ctrl.take) redirectPc <= regQ[REG_VEC] + VEC_OFS;
    else                redirectPc <= '0;
  end

  always_comb begin
    swRdData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (swAddr == SEL_W'(i)) swRdData = regQ[i];
  end

  assign srQ      = regQ[REG_SR];
  assign vecBaseQ = regQ[REG_VEC];

endmodule

// File: rtl/exc_entry_unit.sv
`timescale 1ns/100ps
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int EVT_W   = 12,
  parameter int IMM_W   = 8,
  parameter int WAY_W   = 2,
  parameter int WAY_LSB = 6,
  parameter int VPN_LSB = 10,
  parameter int SR_BL   = 28,
  parameter int SR_RB   = 29,
  parameter int SR_MD   = 30,
  parameter int SEL_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqClass,
  input  logic [EVT_W-1:0] reqEvtCode,
  input  logic [XLEN-1:0]  reqAddr,
  input  logic [WAY_W-1:0] reqWay,
  input  logic [XLEN-1:0]  reqPc,
  input  logic [XLEN-1:0]  reqSr,
  input  logic [IMM_W-1:0] reqImm,
  input  logic             swWrEn,
  input  logic [SEL_W-1:0] swAddr,
  input  logic [XLEN-1:0]  swWrData,
  output logic [XLEN-1:0]  swRdData,
  output logic             redirectValid,
  output logic [XLEN-1:0]  redirectPc
);

  ctrl_t           ctrl;
  logic [XLEN-1:0] srQ;
  logic [XLEN-1:0] vecBaseQ;

  exc_entry_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .reqClass      (reqClass),
    .swWrEn        (swWrEn),
    .swAddr        (swAddr),
    .ctrl          (ctrl),
    .redirectValid (redirectValid)
  );

  exc_entry_dp #(
    .XLEN(XLEN), .EVT_W(EVT_W), .IMM_W(IMM_W), .WAY_W(WAY_W),
    .WAY_LSB(WAY_LSB), .VPN_LSB(VPN_LSB), .SR_BL(SR_BL),
    .SR_RB(SR_RB), .SR_MD(SR_MD), .SEL_W(SEL_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .reqEvtCode (reqEvtCode),
    .reqAddr    (reqAddr),
    .reqWay     (reqWay),
    .reqPc      (reqPc),
    .reqSr      (reqSr),
    .reqImm     (reqImm),
    .swAddr     (swAddr),
    .swWrData   (swWrData),
    .swRdData   (swRdData),
    .redirectPc (redirectPc),
    .srQ        (srQ),
    .vecBaseQ   (vecBaseQ)
  );

endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns/100ps
module exc_entry_chk #(
  parameter int XLEN  = 32,
  parameter int SR_BL = 28,
  parameter int SR_RB = 29,
  parameter int SR_MD = 30
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [1:0]      reqClass,
  input logic [XLEN-1:0] reqSr,
  input logic            redirectValid,
  input logic [XLEN-1:0] redirectPc,
  input logic [XLEN-1:0] srQ,
  input logic [XLEN-1:0] vecBaseQ
);

  localparam logic [XLEN-1:0] KEEP_MASK =
    ~((XLEN'(1) << SR_BL) | (XLEN'(1) << SR_RB) | (XLEN'(1) << SR_MD));

  logic take;
  assign take = reqValid && (reqClass != 2'd3);

  AST_REDIRECT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    take |=> redirectValid); // R6
  AST_NO_STRAY_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    !take |=> !redirectValid); // R7
  AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    take |=> (redirectPc == $past(vecBaseQ) + XLEN'(256))); // R6
  AST_IDLE_PC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !redirectValid |-> (redirectPc == '0)); // R6
  AST_SR_FORCED: assert property (@(posedge clk) disable iff (!rstN)
    take |=> (srQ[SR_BL] && srQ[SR_RB] && srQ[SR_MD])); // R5
  AST_SR_OTHERS: assert property (@(posedge clk) disable iff (!rstN)
    take |=> (((srQ ^ $past(reqSr)) & KEEP_MASK) == '0)); // R5
  AST_SR_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && !take) |=> $stable(srQ)); // R9

endmodule

bind exc_entry_unit exc_entry_chk #(
  .XLEN(XLEN), .SR_BL(SR_BL), .SR_RB(SR_RB), .SR_MD(SR_MD)
) i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .reqValid      (reqValid),
  .reqClass      (reqClass),
  .reqSr         (reqSr),
  .redirectValid (redirectValid),
  .redirectPc    (redirectPc),
  .srQ           (srQ),
  .vecBaseQ      (vecBaseQ)
);

// File: tb/test_exc_entry_unit.sv
`timescale 1ns/100ps
module test_exc_entry_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqClass = 2'd3;
  logic [11:0] reqEvtCode = '0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqWay = '0;
  logic [31:0] reqPc = '0;
  logic [31:0] reqSr = '0;
  logic [7:0]  reqImm = '0;
  logic        swWrEn = 1'b0;
  logic [3:0]  swAddr = '0;
  logic [31:0] swWrData = '0;
  logic [31:0] swRdData;
  logic        redirectValid;
  logic [31:0] redirectPc;

  always #5 clk = ~clk;

  exc_entry_unit i_exc_entry_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqClass(reqClass),
    .reqEvtCode(reqEvtCode), .reqAddr(reqAddr), .reqWay(reqWay),
    .reqPc(reqPc), .reqSr(reqSr), .reqImm(reqImm), .swWrEn(swWrEn),
    .swAddr(swAddr), .swWrData(swWrData), .swRdData(swRdData),
    .redirectValid(redirectValid), .redirectPc(redirectPc)
  );

  // behavioural reference state
  logic [31:0] mReg [9];
  logic        mRedirV;
  logic [31:0] mRedirPc;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(int a);
    case (a)
      0: return "R1";
      1, 2: return "R2";
      3, 4, 5: return "R3";
      6: return "R4";
      7: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic modelEdge();
    logic [31:0] nxt [9];
    bit take;
    nxt = mReg;
    take = reqValid && (reqClass != 2'd3);
    if (swWrEn && !take && !mRedirV && swAddr < 9) nxt[swAddr] = swWrData;
    if (take) begin
      nxt[4] = reqSr;
      nxt[7] = reqSr | 32'h7000_0000;
      if (reqClass == 2'd2) begin
        nxt[3] = reqPc + 2;
        nxt[5] = 32'h160;
        nxt[6] = reqImm * 4;
      end else begin
        nxt[0] = reqAddr;
        nxt[3] = reqPc;
        nxt[5] = {20'd0, reqEvtCode};
        if (reqClass == 2'd0) begin
          nxt[1] = {reqAddr[31:10], mReg[1][9:0]};
          nxt[2][7:6] = reqWay;
        end
      end
    end
    mRedirPc = take ? mReg[8] + 32'h100 : 32'h0;
    mRedirV  = take;
    mReg = nxt;
  endtask

  task automatic compareNow();
    logic [3:0] keep;
    chk(mRedirV ? "R6" : "R7", "redirectValid", {31'd0, redirectValid}, {31'd0, mRedirV});
    chk("R6", "redirectPc", redirectPc, mRedirPc);
    keep = swAddr;
    for (int a = 0; a < 16; a++) begin
      swAddr = 4'(a);
      #0.2;
      chk(tagOf(a), $sformatf("reg%0d", a), swRdData, (a < 9) ? mReg[a] : 32'h0);
    end
    swAddr = keep;
    #0.2;
  endtask

  task automatic cycle();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareNow();
  endtask

  task automatic swWrite(logic [3:0] a, logic [31:0] d);
    swWrEn = 1'b1; swAddr = a; swWrData = d;
    cycle();
    swWrEn = 1'b0;
  endtask

  task automatic excReq(logic [1:0] cls, logic [31:0] addr, logic [31:0] pc,
                        logic [31:0] sr, logic [11:0] evt, logic [1:0] way,
                        logic [7:0] imm);
    reqValid = 1'b1; reqClass = cls; reqAddr = addr; reqPc = pc;
    reqSr = sr; reqEvtCode = evt; reqWay = way; reqImm = imm;
    cycle();
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < 9; i++) mReg[i] = '0;
    mRedirV = 1'b0; mRedirPc = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "redirectValid", {31'd0, redirectValid}, 32'h0);
    for (int a = 0; a < 16; a++) begin
      swAddr = 4'(a);
      #0.2;
      chk("R10", $sformatf("reset reg%0d", a), swRdData, 32'h0);
    end
    swAddr = '0;
    rstN = 1'b1;
    cycle();

    // R8: software writes, out-of-range index ignored
    for (int a = 0; a < 9; a++) swWrite(4'(a), 32'hA5A5_0000 + 32'(a * 32'h111));
    swWrite(4'd12, 32'hDEAD_BEEF);
    swWrite(4'd8, 32'h8000_0000);
    swWrite(4'd1, 32'h0000_03FF);
    swWrite(4'd2, 32'hFFFF_FF3F);

    // R1 R2 R3 R5 R6 with R9: write in redirect cycle dropped
    excReq(2'd0, 32'h1234_5679, 32'h0C00_1000, 32'h0000_00F3, 12'h0A0, 2'd3, 8'h00);
    swWrEn = 1'b1; swAddr = 4'd7; swWrData = 32'h0;
    cycle();
    swWrEn = 1'b0;
    cycle();

    // R1 R3: address error leaves page/way untouched
    excReq(2'd1, 32'hFFFF_0002, 32'h0000_2222, 32'h0000_0001, 12'h100, 2'd1, 8'h55);
    cycle();

    // R4: trap, PC+2, immediate scaled
    excReq(2'd2, 32'h0BAD_0BAD, 32'h0000_0FFE, 32'h8000_0000, 12'h0E0, 2'd2, 8'hFF);
    cycle();
    excReq(2'd2, 32'h0, 32'hFFFF_FFFE, 32'h0, 12'h0, 2'd0, 8'h00);
    cycle();

    // R7: class 3 ignored
    excReq(2'd3, 32'h7777_7777, 32'h3333_3333, 32'h0F0F_0F0F, 12'hFFF, 2'd2, 8'h12);
    cycle();

    // R9: write coinciding with a request dropped
    swWrEn = 1'b1; swAddr = 4'd6; swWrData = 32'h1111_1111;
    excReq(2'd1, 32'h0000_0004, 32'h0000_4444, 32'h0000_0002, 12'h0E0, 2'd0, 8'h01);
    swWrEn = 1'b0;
    cycle();

    // R6: back-to-back requests after a vector base change
    swWrite(4'd8, 32'h0000_4000);
    excReq(2'd2, 32'h0, 32'h0000_0100, 32'h0000_0010, 12'h0, 2'd0, 8'h40);
    excReq(2'd0, 32'hC000_0400, 32'h0000_0200, 32'h0000_0020, 12'h0C0, 2'd0, 8'h00);
    cycle();
    cycle();

    finishRun();
  end

endmodule